// File: doc/BRIEF.md
# Status Register and Write-Permission Unit

This block keeps the 8-bit status register of a serial nonvolatile memory controller and rules on every write the command engine wants to perform. The command engine sends one-cycle event pulses (write-enable set, write-enable clear, wake from deep power down, opcode complete, status write), the level of the external write-protect pin and the target address of the current array access. The block returns the register image for status reads and three registered permission flags: one for the main array, one for the status register and one for the identity and special-sector regions.

The upper six bits of the register are written by a status-write command. Two of them select how much of the array, counted downward from its top, is locked. The top bit, a protect-enable bit, makes the status register itself writable only while the write-protect pin is high. The write-enable latch is set and cleared only by dedicated events and by reset. It is not cleared when a write completes, so a host can issue write commands back to back. The pin level is captured when an opcode finishes and held for the rest of that command, so a pin change in the middle of a command cannot alter its outcome.

Top module: `wprot_status_unit`

## Requirements
- R1: After reset, status_q[7:2] equals NV_INIT[7:2] (all zero by default), the write-enable latch status_q[1] is 0, and all three permission flags are 0.
- R2: status_q[0] always reads 0. An accepted status write loads data bits 7:2 into status_q[7:2] and ignores data bits 1 and 0.
- R3: ev_we_set sets status_q[1]. ev_we_clr and ev_pd_exit clear it. When a clear and a set arrive in the same cycle, the clear wins.
- R4: An accepted status write leaves status_q[1] set. No write event clears the latch.
- R5: With the latch set, the array flag is 0 for a locked address and 1 otherwise. Let E be the address with bits at or above ARR_AW masked and S = 2^ARR_AW. The lock code status_q[3:2] means: 00 locks nothing, 01 locks E >= 3S/4, 10 locks E >= S/2, and 11 locks every address.
- R6: While status_q[1] is 0, all three permission flags are 0, and a status write request leaves status_q unchanged.
- R7: With the latch set, the status flag is 1 when status_q[7] is 0, or when status_q[7] is 1 and the held pin level is 1. It is 0 when status_q[7] is 1 and the held pin level is 0. A status write request that is refused leaves status_q unchanged. The auxiliary flag equals the latch.
- R8: The pin level is captured only on ev_opcode_done. Pin changes at any other time have no effect on the status flag until the next opcode completes.
- R9: Address bits at and above ARR_AW do not affect the array flag.
- R10: Each permission flag is registered. It reflects the register, the held pin level and the address as they stood one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ev_we_set | input | 1 | Pulse: set the write-enable latch |
| ev_we_clr | input | 1 | Pulse: clear the write-enable latch |
| ev_pd_exit | input | 1 | Pulse: return from deep power down, clears the latch |
| ev_opcode_done | input | 1 | Pulse: opcode complete, capture the write-protect pin |
| wp_pin | input | 1 | External write-protect pin level |
| ev_status_wr | input | 1 | Pulse: status write request carrying status_wr_data |
| status_wr_data | input | 8 | Data byte of the status write |
| addr | input | ADDR_W | Target array address |
| status_q | output | 8 | Status register image |
| array_wr_ok | output | 1 | Array write permitted at addr |
| status_wr_ok | output | 1 | Status register write permitted |
| aux_wr_ok | output | 1 | Identity / special-sector write permitted |

## Verification
The bench sweeps every combination of latch, protect-enable bit, held pin level and lock code against every address of a small configuration. That sweep catches a lock boundary off by one, or lock codes swapped: either would grant a write to the first locked address or refuse one just below the boundary. It also writes status data with bits 1 and 0 set. A design that copies those bits would corrupt the latch or the constant-zero bit. Further checks cover a pin toggled with no opcode (a design that follows the pin directly would change the status flag), a status write refused while locked (a design that ignores the permission would overwrite the register), and a set that collides with a clear or a wake from power down (a design with the wrong priority would leave writes enabled).

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef struct packed {
    logic       prot_en;  // bit 7: gates status writes with the pin
    logic [2:0] spare;    // bits 6:4: free, writable
    logic [1:0] lock;     // bits 3:2: array lock code
    logic       we;       // bit 1: write-enable latch
    logic       zero;     // bit 0: reads as 0
  } stat_t;

  localparam logic [1:0] LOCK_NONE    = 2'b00;
  localparam logic [1:0] LOCK_QUARTER = 2'b01;
  localparam logic [1:0] LOCK_HALF    = 2'b10;
  localparam logic [1:0] LOCK_ALL     = 2'b11;

endpackage

// File: rtl/wprot_status_reg.sv
module wprot_status_reg
  import wprot_pkg::*;
#(
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we_set,
  input  logic       we_clr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output stat_t      q
);

  stat_t init_img;
  stat_t data_img;

  assign init_img = stat_t'(NV_INIT);
  assign data_img = stat_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      q.prot_en <= init_img.prot_en;
      q.spare   <= init_img.spare;
      q.lock    <= init_img.lock;
      q.we      <= 1'b0;
      q.zero    <= 1'b0;
    end else begin
      if (wr_en) begin
        q.prot_en <= data_img.prot_en;
        q.spare   <= data_img.spare;
        q.lock    <= data_img.lock;
      end
      if (we_clr)      q.we <= 1'b0;
      else if (we_set) q.we <= 1'b1;
      q.zero <= 1'b0;
    end
  end

endmodule

// File: rtl/wprot_range.sv
module wprot_range #(
  parameter int ADDR_W = 16,
  parameter int ARR_AW = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lock,
  output logic              locked
);

  localparam logic [ADDR_W-1:0] SIZE  = ADDR_W'(1) << ARR_AW;
  localparam logic [ADDR_W-1:0] MASK  = SIZE - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HALF  = SIZE >> 1;
  localparam logic [ADDR_W-1:0] UPPER = SIZE - (SIZE >> 2);

  logic [ADDR_W-1:0] eff;
  assign eff = addr & MASK;

  always_comb begin
    unique case (lock)
      wprot_pkg::LOCK_NONE:    locked = 1'b0;
      wprot_pkg::LOCK_QUARTER: locked = (eff >= UPPER);
      wprot_pkg::LOCK_HALF:    locked = (eff >= HALF);
      default:                 locked = 1'b1;
    endcase
  end

endmodule

// File: rtl/wprot_policy.sv
module wprot_policy (
  input  logic we,
  input  logic prot_en,
  input  logic wp_held,
  input  logic locked,
  output logic arr_ok,
  output logic st_ok,
  output logic aux_ok
);

  assign arr_ok = we & ~locked;
  assign st_ok  = we & (~prot_en | wp_held);
  assign aux_ok = we;

endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
  import wprot_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         ARR_AW  = 15,
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_we_set,
  input  logic              ev_we_clr,
  input  logic              ev_pd_exit,
  input  logic              ev_opcode_done,
  input  logic              wp_pin,
  input  logic              ev_status_wr,
  input  logic [7:0]        status_wr_data,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_q,
  output logic              array_wr_ok,
  output logic              status_wr_ok,
  output logic              aux_wr_ok
);

  stat_t st;
  logic  wp_held;
  logic  locked;
  logic  arr_ok_c, st_ok_c, aux_ok_c;

  always_ff @(posedge clk) begin
    if (rst)                 wp_held <= 1'b0;
    else if (ev_opcode_done) wp_held <= wp_pin;
  end

  wprot_status_reg #(.NV_INIT(NV_INIT)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .we_set  (ev_we_set),
    .we_clr  (ev_we_clr | ev_pd_exit),
    .wr_en   (ev_status_wr & st_ok_c),
    .wr_data (status_wr_data),
    .q       (st)
  );

  wprot_range #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW)) u_range (
    .addr   (addr),
    .lock   (st.lock),
    .locked (locked)
  );

  wprot_policy u_policy (
    .we      (st.we),
    .prot_en (st.prot_en),
    .wp_held (wp_held),
    .locked  (locked),
    .arr_ok  (arr_ok_c),
    .st_ok   (st_ok_c),
    .aux_ok  (aux_ok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      array_wr_ok  <= 1'b0;
      status_wr_ok <= 1'b0;
      aux_wr_ok    <= 1'b0;
    end else begin
      array_wr_ok  <= arr_ok_c;
      status_wr_ok <= st_ok_c;
      aux_wr_ok    <= aux_ok_c;
    end
  end

  assign status_q = st;

endmodule

// File: rtl/wprot_status_chk.sv
module wprot_status_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_we_set,
  input logic              ev_we_clr,
  input logic              ev_pd_exit,
  input logic              ev_status_wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        status_q,
  input logic              array_wr_ok,
  input logic              status_wr_ok,
  input logic              aux_wr_ok
);

  assert_we_set_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_we_set && !ev_we_clr && !ev_pd_exit) |=> status_q[1]);

  assert_we_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_we_clr || ev_pd_exit) |=> !status_q[1]);

  assert_we_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (ev_status_wr && status_q[1] && !ev_we_clr && !ev_pd_exit) |=> status_q[1]);

  assert_no_grant_R6: assert property (@(posedge clk) disable iff (rst)
    !status_q[1] |=> (!array_wr_ok && !status_wr_ok && !aux_wr_ok));

  assert_refused_write_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_status_wr && !status_q[1]) |=> (status_q[7:2] == $past(status_q[7:2])));

  assert_lock_all_R5: assert property (@(posedge clk) disable iff (rst)
    (status_q[3:2] == 2'b11) |=> !array_wr_ok);

  assert_aux_follows_R7: assert property (@(posedge clk) disable iff (rst)
    status_q[1] && !ev_we_clr && !ev_pd_exit |=> ##1 aux_wr_ok);

  assert_zero_bit_R2: assert property (@(posedge clk) disable iff (rst)
    ev_status_wr |=> !status_q[0]);

  logic unused_addr;
  assign unused_addr = ^addr;

endmodule

bind wprot_status_unit wprot_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_we_set    (ev_we_set),
  .ev_we_clr    (ev_we_clr),
  .ev_pd_exit   (ev_pd_exit),
  .ev_status_wr (ev_status_wr),
  .addr         (addr),
  .status_q     (status_q),
  .array_wr_ok  (array_wr_ok),
  .status_wr_ok (status_wr_ok),
  .aux_wr_ok    (aux_wr_ok)
);

// File: tb/test_wprot_status_unit.sv
`timescale 1ns/1ps
module test_wprot_status_unit;

  localparam int ADDR_W = 6;
  localparam int ARR_AW = 5;
  localparam int SIZE   = 1 << ARR_AW;

  logic              clk = 1'b0;
  logic              rst;
  logic              ev_we_set, ev_we_clr, ev_pd_exit, ev_opcode_done, wp_pin, ev_status_wr;
  logic [7:0]        status_wr_data;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        status_q;
  logic              array_wr_ok, status_wr_ok, aux_wr_ok;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wprot_status_unit #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .NV_INIT(8'h00)) i_wprot_status_unit (
    .clk(clk), .rst(rst), .ev_we_set(ev_we_set), .ev_we_clr(ev_we_clr),
    .ev_pd_exit(ev_pd_exit), .ev_opcode_done(ev_opcode_done), .wp_pin(wp_pin),
    .ev_status_wr(ev_status_wr), .status_wr_data(status_wr_data), .addr(addr),
    .status_q(status_q), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok),
    .aux_wr_ok(aux_wr_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_ev();
    ev_we_set = 0; ev_we_clr = 0; ev_pd_exit = 0; ev_opcode_done = 0; ev_status_wr = 0;
  endtask

  task automatic we_set();   ev_we_set = 1; cyc(1); clear_ev(); endtask
  task automatic we_clr();   ev_we_clr = 1; cyc(1); clear_ev(); endtask
  task automatic opcode(input logic p); wp_pin = p; ev_opcode_done = 1; cyc(1); clear_ev(); endtask
  task automatic st_write(input logic [7:0] d);
    status_wr_data = d; ev_status_wr = 1; cyc(1); clear_ev();
  endtask

  function automatic logic exp_arr(input logic we, input int lk, input int a);
    int e;
    int lim;
    e = a % SIZE;
    lim = (lk == 0) ? SIZE : (lk == 1) ? (3 * SIZE) / 4 : (lk == 2) ? SIZE / 2 : 0;
    return we && (e < lim);
  endfunction

  initial begin
    #1200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_ev(); wp_pin = 0; status_wr_data = 0; addr = 0; rst = 1;
    cyc(3);
    // R1: reset state
    chk("R1 status", status_q, 8'h00);
    chk("R1 flags", {5'b0, array_wr_ok, status_wr_ok, aux_wr_ok}, 8'h00);
    rst = 0;
    cyc(2);
    chk("R1 flags after release", {5'b0, array_wr_ok, status_wr_ok, aux_wr_ok}, 8'h00);

    // R6: status write refused while latch clear
    st_write(8'hFC);
    chk("R6 refused write", status_q, 8'h00);

    // Exhaustive sweep: R2 R5 R6 R7 R9 R10
    for (int pe = 0; pe < 2; pe++)
      for (int lk = 0; lk < 4; lk++)
        for (int wp = 0; wp < 2; wp++)
          for (int we = 0; we < 2; we++) begin
            logic [7:0] img;
            we_set();
            opcode(1'b1);
            img = {pe[0], 3'b101, lk[1:0], 2'b11};
            st_write(img);
            // R2: bits 1:0 of data ignored, bit 0 zero, latch kept (R4)
            chk("R2 R4 status load", status_q, {pe[0], 3'b101, lk[1:0], 2'b10});
            opcode(wp[0]);
            if (we == 0) we_clr();
            for (int a = 0; a < (1 << ADDR_W); a++) begin
              addr = a[ADDR_W-1:0];
              cyc(1); // R10: flags registered one edge after the address
              chk("R5 R9 array flag", {7'b0, array_wr_ok}, {7'b0, exp_arr(we[0], lk, a)});
            end
            chk("R7 status flag", {7'b0, status_wr_ok}, {7'b0, (we[0] && (!pe[0] || wp[0]))});
            chk("R7 aux flag", {7'b0, aux_wr_ok}, {7'b0, we[0]});
            if (we == 0) chk("R6 array blocked", {7'b0, array_wr_ok}, 8'h00);
          end

    // R8: pin sampled only at opcode completion
    we_set(); opcode(1'b1);
    st_write(8'h80);
    chk("R8 setup", status_q, 8'h82);
    wp_pin = 0; cyc(3);
    chk("R8 pin change ignored", {7'b0, status_wr_ok}, 8'h01);
    st_write(8'h84);
    chk("R8 write still accepted", status_q, 8'h86);
    opcode(1'b0); cyc(1);
    chk("R8 new sample", {7'b0, status_wr_ok}, 8'h00);
    // R7: refused status write leaves register
    st_write(8'h00);
    chk("R7 refused write", status_q, 8'h86);
    wp_pin = 1; cyc(2);
    chk("R7 no resample without opcode", {7'b0, status_wr_ok}, 8'h00);

    // R3: priority and power-down wake
    opcode(1'b1);
    st_write(8'h00);
    chk("R3 setup", status_q, 8'h02);
    ev_we_set = 1; ev_we_clr = 1; cyc(1); clear_ev();
    chk("R3 clear wins", status_q[1], 1'b0);
    we_set();
    chk("R3 set", status_q[1], 1'b1);
    ev_we_set = 1; ev_pd_exit = 1; cyc(1); clear_ev();
    chk("R3 wake clears", status_q[1], 1'b0);
    we_set(); ev_pd_exit = 1; cyc(1); clear_ev();
    chk("R3 wake clears alone", status_q[1], 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule